// File: doc/BRIEF.md
# Delayed Read Request Queue

This block keeps track of read requests that a two-port bus bridge has accepted as delayed transactions and is still completing on the far bus. It has one small queue for each crossing direction. Every entry holds the target address, a command class and a completion flag. Whenever an initiator presents a read, the block looks it up in the queue for that direction. The lookup answers in the same cycle with one of four codes: the read was accepted as a new entry, it is already pending, its completion is ready to hand over, or the queue is full and the initiator must retry.

Completions from the far bus mark entries as done, oldest first. When the completed entry at the head also has its data at the head of the read data queue (signalled per direction by `rdata_at_head`), a countdown runs. If the initiator does not return before it runs out, the entry is thrown away. At that point the block pulses `expire` for that direction and, if `serr_en` allows it, raises `serr`. The countdown's start value comes from an internal register that software loads through `cfg_tmo_wr`.

Top module: `dly_read_queue`

## Requirements
- R1: When matching, the three memory read codes 4'b0110, 4'b1110 and 4'b1100 count as one command class. Any other code, for example I/O read 4'b0010, matches only itself.
- R2: A lookup (`req_valid`=1) whose address and command class equal a queued entry of the same direction creates no new entry. The result code is 1 (pending) if that entry is not complete or is not at the head. It is 2 (ready) if the entry is complete and at the head. A lookup with no match that is accepted returns 0 (new).
- R3: Each direction holds at most DEPTH (4) entries. A non-matching lookup to a full direction returns 3 (retry) and is not stored. A matching lookup to a full direction still returns 1 or 2.
- R4: The two directions (`req_dir`/`cpl_dir` 0 and 1) have separate queues, completions and countdowns.
- R5: A `cpl_valid` pulse marks the oldest not-yet-complete entry of `cpl_dir` as complete. A ready (code 2) lookup removes the head entry at the next clock edge.
- R6: Entries reach the head and leave the queue in the order they were stored.
- R7: The countdown of a direction decrements once per clock only while its head entry is complete and `rdata_at_head` for that direction is 1. With start value N, `expire` goes high on the Nth such cycle.
- R8: The start-value register resets to 32768 and takes `cfg_tmo_val` on a clock edge where `cfg_tmo_wr` is 1.
- R9: On expiry the head entry is discarded at that clock edge, so its slot is free from the next cycle. `serr` is high exactly when some `expire` bit is high and `serr_en` is 1.
- R10: The countdown reloads the start value whenever a new entry becomes head. A ready lookup in the same cycle as the last count takes precedence, and no expiry is signalled.
- R11: After reset both queues are empty, and `expire` and `serr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A read lookup is presented this cycle |
| req_dir | input | 1 | Direction of the lookup |
| req_addr | input | ADDR_W | Address of the read |
| req_cmd | input | 4 | Bus command code of the read |
| req_result | output | 2 | 0 new, 1 pending, 2 ready, 3 retry; meaningful while req_valid |
| cpl_valid | input | 1 | The far bus completed the oldest open read |
| cpl_dir | input | 1 | Direction of that completion |
| rdata_at_head | input | 2 | Per direction: head read data is at the head of the data queue |
| cfg_tmo_wr | input | 1 | Load the countdown start value |
| cfg_tmo_val | input | TMO_W | New start value |
| serr_en | input | 1 | Allows the error indication on expiry |
| expire | output | 2 | Per direction: the head entry is discarded this cycle |
| serr | output | 1 | Error indication on expiry |

## Verification
The bench uses the default parameters: 32-bit addresses, a queue depth of 4 and a 16-bit countdown. With a depth of 4, a handful of lookups fills a direction, so the retry response and matching into a full queue are both reached. Loading a start value of 5 brings expiry, reload and the race between a ready lookup and the countdown down to a few cycles. The 16-bit width keeps the reset value of 32768 short enough to run to expiry and count exactly.

// File: rtl/dly_read_queue.sv
module dly_read_queue #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int TMO_W  = 16,
  parameter logic [TMO_W-1:0] TMO_RST = TMO_W'(32768)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_dir,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_cmd,
  output logic [1:0]        req_result,
  input  logic              cpl_valid,
  input  logic              cpl_dir,
  input  logic [1:0]        rdata_at_head,
  input  logic              cfg_tmo_wr,
  input  logic [TMO_W-1:0]  cfg_tmo_val,
  input  logic              serr_en,
  output logic [1:0]        expire,
  output logic              serr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] RES_NEW   = 2'd0;
  localparam logic [1:0] RES_PEND  = 2'd1;
  localparam logic [1:0] RES_READY = 2'd2;
  localparam logic [1:0] RES_RETRY = 2'd3;
  localparam logic [3:0] CMD_MRD = 4'b0110;
  localparam logic [3:0] CMD_MRL = 4'b1110;
  localparam logic [3:0] CMD_MRM = 4'b1100;

  function automatic logic [3:0] cmd_class(input logic [3:0] c);
    return (c == CMD_MRL || c == CMD_MRM) ? CMD_MRD : c;
  endfunction

  function automatic logic [PW-1:0] slot_at(input logic [PW-1:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [ADDR_W-1:0] addr_q [2][DEPTH];
  logic [3:0]        cls_q  [2][DEPTH];
  logic [PW-1:0]     rd_p   [2];
  logic [PW-1:0]     wr_p   [2];
  logic [CW-1:0]     cnt_q  [2];
  logic [CW-1:0]     done_q [2];
  logic [TMO_W-1:0]  tmr_q  [2];
  logic [TMO_W-1:0]  tmo_cfg;

  logic [3:0]    req_cls;
  logic          hit;
  logic [CW-1:0] hit_k;
  logic          full, head_ready, enq, take;
  logic [1:0]    run, stop, push, pop, mark, reload;

  assign req_cls = cmd_class(req_cmd);

  always_comb begin
    hit   = 1'b0;
    hit_k = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!hit && CW'(k) < cnt_q[req_dir] &&
          addr_q[req_dir][slot_at(rd_p[req_dir], k)] == req_addr &&
          cls_q[req_dir][slot_at(rd_p[req_dir], k)] == req_cls) begin
        hit   = 1'b1;
        hit_k = CW'(k);
      end
    end
  end

  assign full       = cnt_q[req_dir] == CW'(DEPTH);
  assign head_ready = hit && hit_k == '0 && done_q[req_dir] != '0;
  assign enq        = req_valid && !hit && !full;
  assign take       = req_valid && head_ready;

  assign req_result = !req_valid ? RES_NEW :
                      hit        ? (head_ready ? RES_READY : RES_PEND) :
                      full       ? RES_RETRY : RES_NEW;

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      run[d]    = cnt_q[d] != '0 && done_q[d] != '0 && rdata_at_head[d];
      stop[d]   = take && req_dir == 1'(d);
      push[d]   = enq && req_dir == 1'(d);
      expire[d] = run[d] && !stop[d] && tmr_q[d] <= TMO_W'(1);
      pop[d]    = stop[d] || expire[d];
      mark[d]   = cpl_valid && cpl_dir == 1'(d) && done_q[d] < cnt_q[d];
      reload[d] = pop[d] || (push[d] && cnt_q[d] == '0);
    end
  end

  assign serr = serr_en && (expire != 2'b00);

  always_ff @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (push[d]) begin
        addr_q[d][wr_p[d]] <= req_addr;
        cls_q[d][wr_p[d]]  <= req_cls;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cfg <= TMO_RST;
      for (int d = 0; d < 2; d++) begin
        rd_p[d]   <= '0;
        wr_p[d]   <= '0;
        cnt_q[d]  <= '0;
        done_q[d] <= '0;
        tmr_q[d]  <= TMO_RST;
      end
    end else begin
      if (cfg_tmo_wr) tmo_cfg <= cfg_tmo_val;
      for (int d = 0; d < 2; d++) begin
        if (push[d]) wr_p[d] <= ptr_inc(wr_p[d]);
        if (pop[d])  rd_p[d] <= ptr_inc(rd_p[d]);
        cnt_q[d]  <= cnt_q[d] + CW'(push[d]) - CW'(pop[d]);
        done_q[d] <= done_q[d] + CW'(mark[d]) - CW'(pop[d]);
        if (reload[d])
          tmr_q[d] <= tmo_cfg;
        else if (run[d] && tmr_q[d] != '0)
          tmr_q[d] <= tmr_q[d] - TMO_W'(1);
      end
    end
  end
endmodule

module dly_read_queue_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_dir,
  input logic [1:0]    req_result,
  input logic [1:0]    rdata_at_head,
  input logic          serr_en,
  input logic [1:0]    expire,
  input logic          serr,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] done0,
  input logic [CW-1:0] done1
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt0 <= CW'(DEPTH) && cnt1 <= CW'(DEPTH));

  p_retry_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_result == 2'd3) |-> ((req_dir ? cnt1 : cnt0) == CW'(DEPTH)));

  p_done_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done0 <= cnt0 && done1 <= cnt1);

  p_ready_pops_d0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_dir && req_result == 2'd2) |=> (cnt0 == $past(cnt0) - CW'(1)));

  p_ready_pops_d1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dir && req_result == 2'd2) |=> (cnt1 == $past(cnt1) - CW'(1)));

  p_expire_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |-> (rdata_at_head[0] && done0 != '0));

  p_expire_gate_d1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] |-> (rdata_at_head[1] && done1 != '0));

  p_serr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> (serr_en && expire != 2'b00));
endmodule

bind dly_read_queue dly_read_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
  .req_result(req_result), .rdata_at_head(rdata_at_head), .serr_en(serr_en),
  .expire(expire), .serr(serr),
  .cnt0(cnt_q[0]), .cnt1(cnt_q[1]), .done0(done_q[0]), .done1(done_q[1])
);

// File: tb/dly_read_queue_tb.sv
module dly_read_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_dir = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [1:0]  req_result;
  logic        cpl_valid = 1'b0, cpl_dir = 1'b0;
  logic [1:0]  rdata_at_head = 2'b00;
  logic        cfg_tmo_wr = 1'b0;
  logic [15:0] cfg_tmo_val = '0;
  logic        serr_en = 1'b0;
  logic [1:0]  expire;
  logic        serr;

  int nchk = 0, nerr = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  dly_read_queue dut_i (.*);

  localparam logic [1:0] NEW = 2'd0, PEND = 2'd1, RDY = 2'd2, RETRY = 2'd3;

  // {req[44:41], op[40:39] 0=lookup 1=complete, dir[38], cmd[37:34], addr[33:2], exp[1:0]}
  localparam int NV = 20;
  localparam logic [44:0] VEC [NV] = '{
    {4'd2, 2'd0, 1'b0, 4'h6, 32'h1000, NEW},   // R2 first read accepted
    {4'd1, 2'd0, 1'b0, 4'hE, 32'h1000, PEND},  // R1 line variant aliases
    {4'd1, 2'd0, 1'b0, 4'hC, 32'h1000, PEND},  // R1 multiple variant aliases
    {4'd1, 2'd0, 1'b0, 4'h2, 32'h1000, NEW},   // R1 I/O read is its own class
    {4'd2, 2'd0, 1'b0, 4'h6, 32'h2000, NEW},
    {4'd2, 2'd0, 1'b0, 4'h6, 32'h3000, NEW},
    {4'd3, 2'd0, 1'b0, 4'h6, 32'h4000, RETRY}, // R3 full
    {4'd3, 2'd0, 1'b0, 4'hE, 32'h3000, PEND},  // R3 match while full
    {4'd4, 2'd0, 1'b1, 4'h6, 32'h4000, NEW},   // R4 other direction free
    {4'd5, 2'd1, 1'b0, 4'h0, 32'h0,    NEW},   // R5 complete oldest
    {4'd5, 2'd0, 1'b0, 4'h6, 32'h2000, PEND},
    {4'd5, 2'd0, 1'b0, 4'hC, 32'h1000, RDY},   // R5 head ready, pops
    {4'd5, 2'd0, 1'b0, 4'h6, 32'h1000, NEW},   // R5 removed entry gone
    {4'd3, 2'd0, 1'b0, 4'h6, 32'h5000, RETRY},
    {4'd6, 2'd1, 1'b0, 4'h0, 32'h0,    NEW},
    {4'd6, 2'd1, 1'b0, 4'h0, 32'h0,    NEW},
    {4'd6, 2'd0, 1'b0, 4'h6, 32'h2000, PEND},  // R6 done but not head
    {4'd6, 2'd0, 1'b0, 4'h2, 32'h1000, RDY},   // R6 head in order
    {4'd6, 2'd0, 1'b0, 4'hE, 32'h2000, RDY},   // R6 next in order
    {4'd4, 2'd0, 1'b1, 4'hC, 32'h4000, PEND}   // R4 other direction kept
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic lookup(input logic d, input logic [31:0] a, input logic [3:0] c,
                        input logic [1:0] exp, input string what);
    @(negedge clk);
    req_valid = 1'b1; req_dir = d; req_addr = a; req_cmd = c;
    cpl_valid = 1'b0; cfg_tmo_wr = 1'b0;
    #2 chk(32'(req_result), 32'(exp), what);
  endtask

  task automatic complete(input logic d);
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b1; cpl_dir = d; cfg_tmo_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0; cfg_tmo_wr = 1'b0;
  endtask

  task automatic set_tmo(input logic [15:0] v);
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0; cfg_tmo_wr = 1'b1; cfg_tmo_val = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0; cfg_tmo_wr = 1'b0;
    rdata_at_head = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // expire[0] low for n-1 negedges, high on the nth
  task automatic watch0(input int n, input logic exp_serr, input string what);
    for (int i = 1; i <= n; i++) begin
      idle();
      #1 chk(32'(expire[0]), (i == n) ? 32'd1 : 32'd0, what);
      if (i == n) chk(32'(serr), 32'(exp_serr), {what, " serr"});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nerr++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    chk(32'(expire), 32'd0, "R11 expire in reset");
    chk(32'(serr), 32'd0, "R11 serr in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_tmo_wr = 1'b0;
      if (VEC[i][40:39] == 2'd0) begin
        req_valid = 1'b1; req_dir = VEC[i][38]; req_cmd = VEC[i][37:34];
        req_addr = VEC[i][33:2]; cpl_valid = 1'b0;
        #2 chk(32'(req_result), 32'(VEC[i][1:0]),
               $sformatf("R%0d vector %0d", VEC[i][44:41], i));
      end else begin
        req_valid = 1'b0; cpl_valid = 1'b1; cpl_dir = VEC[i][38];
      end
    end
    idle();

    // R11 reset empties the queues
    do_reset();
    lookup(1'b0, 32'h2000, 4'h6, NEW, "R11 queue empty after reset");
    chk(32'(expire), 32'd0, "R11 no expire after reset");

    // R7 R9 countdown with start value 5
    do_reset();
    set_tmo(16'd5);
    serr_en = 1'b1; rdata_at_head = 2'b01;
    lookup(1'b0, 32'hA000, 4'h6, NEW, "R7 enqueue");
    complete(1'b0);
    watch0(5, 1'b1, "R7 expiry after 5 running cycles");
    lookup(1'b0, 32'hA000, 4'h6, NEW, "R9 discarded entry slot free");

    // R7 countdown holds while data is not at head; R9 serr gated
    rdata_at_head = 2'b00; serr_en = 1'b0;
    complete(1'b0);
    for (int i = 0; i < 8; i++) begin
      idle();
      #1 chk(32'(expire[0]), 32'd0, "R7 no count without head data");
    end
    rdata_at_head = 2'b01;
    watch0(4, 1'b0, "R9 expiry with serr disabled");

    // R10 ready lookup stops countdown, next head reloads
    serr_en = 1'b1;
    lookup(1'b0, 32'hB000, 4'h6, NEW, "R10 enqueue first");
    lookup(1'b0, 32'hC000, 4'hE, NEW, "R10 enqueue second");
    complete(1'b0);
    complete(1'b0);
    idle();
    #1 chk(32'(expire[0]), 32'd0, "R10 counting");
    idle();
    #1 chk(32'(expire[0]), 32'd0, "R10 counting");
    lookup(1'b0, 32'hB000, 4'hC, RDY, "R10 ready before expiry");
    chk(32'(expire[0]), 32'd0, "R10 no expiry on ready cycle");
    watch0(5, 1'b1, "R10 reload for new head");

    // R8 power-on start value, direction 1 (R4)
    do_reset();
    serr_en = 1'b1; rdata_at_head = 2'b10;
    lookup(1'b1, 32'hD000, 4'h2, NEW, "R8 enqueue");
    complete(1'b1);
    begin
      int n;
      n = 0;
      do begin
        idle();
        #1 n++;
      end while (expire[1] !== 1'b1 && n < 40000);
      chk(32'(n), 32'd32768, "R8 reset start value");
      chk(32'(serr), 32'd1, "R9 serr on expiry");
      chk(32'(expire[0]), 32'd0, "R4 other direction quiet");
    end
    idle();

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule